// File: doc/BRIEF.md
# Successive-Approximation Converter Control Interface

This block is the digital side of a 12-bit successive-approximation converter as a processor bus sees it. A chip select, a read/convert strobe and a byte-select input control it. It drives an active-low busy flag, a hold/track control for the external sampler, a trial code for the external capacitor DAC, and a 12-line three-state data bus. The bus is modelled as a data word plus a single output enable.

A falling edge on the read/convert strobe starts a conversion. The strobe first passes through a two-flop synchronizer. The edge counts only when chip select and byte-select are both low and no conversion is running. The controller then runs one trial per result bit, from the most significant bit down, with a parameterised number of clocks per trial. It latches the result and only then releases busy. The result can be read as one 12-bit word or, for an 8-bit bus, with the top four bits moved to the low nibble of the bus. Two ways of using the strobe are supported. In one, the strobe idles high and a short low pulse converts. In the other, the strobe idles low and a high pulse first puts the last result on the bus and then, on its falling edge, starts the next conversion.

Top module: `sar_conv_top`

## Requirements
- R1: A conversion starts only when the synchronized strobe goes from high to low while csN is 0, hiByteEn is 0 and busyN is 1. A falling edge under any other condition leaves busyN at 1.
- R2: Once started, busyN stays 0 for exactly WIDTH*STEP_CYCLES+1 clock cycles. The result is already in the output latch in the cycle busyN returns to 1.
- R3: While busyN is 0, dataOe is 0 and edges on the strobe have no effect. The conversion length is unchanged and no new conversion follows.
- R4: While csN is 1, dataOe is 0.
- R5: With hiByteEn at 0, dataOut carries the full result with bit 11 as the MSB.
- R6: With hiByteEn at 1, dataOut[11:8] and dataOut[3:0] both carry result bits 11..8, and dataOut[7:4] are 0.
- R7: dataOe is 1 when csN is 0, busyN is 1 and the synchronized strobe is high. In read mode, a high pulse therefore shows the previous result before its falling edge starts the next conversion.
- R8: The trial code starts at the MSB alone. Each trial keeps its bit when cmpHigh is 1 (input at or above the DAC level) and clears it otherwise, then sets the next lower bit. For a comparator that reports input >= dacCode, the result equals the input code (offset binary).
- R9: holdEn (1 = hold) is 1 from the first busy cycle through the last trial. It is 0 in the final busy cycle, so that tracking restarts just before busyN rises, and it stays 0 while idle.
- R10: After reset, busyN is 1, holdEn is 0, the result latch is 0 and dataOe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| rdConv | input | 1 | Read/convert strobe (asynchronous) |
| hiByteEn | input | 1 | 1 selects byte-steered output |
| cmpHigh | input | 1 | Comparator: analog input >= DAC level |
| dacCode | output | WIDTH | Trial code for the capacitor DAC |
| holdEn | output | 1 | 1 = sampler in hold, 0 = track |
| busyN | output | 1 | 0 while converting |
| dataOut | output | WIDTH | Bus data word |
| dataOe | output | 1 | Bus output enable (0 = high impedance) |

## Verification
The checker verifies every cycle that the bus is disabled during busy and under a high chip select, and that the byte-steered nibble is low. It also verifies that busy lasts exactly the step count, that hold falls one cycle before busy rises, that each start saw select and byte-select low, and that each conversion begins at the MSB trial. Only the bench scenarios show the converged result for given input codes, including the extremes and the mid-scale neighbours. The same holds for the read-mode display of the previous result, for strobe pulses during busy being ignored, and for starts refused under a high select or byte-select.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;
  typedef enum logic [1:0] {
    ST_TRACK = 2'd0,
    ST_CONV  = 2'd1,
    ST_XFER  = 2'd2
  } convState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic start;   // load MSB trial
    logic decide;  // resolve current trial bit
    logic commit;  // copy code into result latch
  } sarStrobe_t;
endpackage

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_conv_pkg::*;
#(
  parameter int WIDTH       = 12,
  parameter int STEP_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       rdConv,
  input  logic       hiByteEn,
  output sarStrobe_t strobe,
  output logic       busyN,
  output logic       holdEn,
  output logic       rcLevel
);
  localparam int STEP_W = $clog2(STEP_CYCLES) + 1;
  localparam int BIT_W  = $clog2(WIDTH);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_CYCLES - 1);
  localparam logic [BIT_W-1:0]  BIT_TOP   = BIT_W'(WIDTH - 1);

  logic rcMeta, rcSync, rcPrev;
  convState_e state;
  logic [STEP_W-1:0] stepCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic startReq, stepEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rcMeta <= 1'b0;
      rcSync <= 1'b0;
      rcPrev <= 1'b0;
    end else begin
      rcMeta <= rdConv;
      rcSync <= rcMeta;
      rcPrev <= rcSync;
    end
  end

  assign startReq = rcPrev & ~rcSync & ~csN & ~hiByteEn & (state == ST_TRACK);
  assign stepEnd  = (state == ST_CONV) && (stepCnt == STEP_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_TRACK;
      stepCnt <= '0;
      bitCnt  <= '0;
    end else begin
      unique case (state)
        ST_TRACK: if (startReq) begin
          state   <= ST_CONV;
          stepCnt <= '0;
          bitCnt  <= BIT_TOP;
        end
        ST_CONV: begin
          if (stepEnd) begin
            stepCnt <= '0;
            if (bitCnt == '0) state <= ST_XFER;
            else bitCnt <= bitCnt - 1'b1;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        ST_XFER: state <= ST_TRACK;
        default: state <= ST_TRACK;
      endcase
    end
  end

  assign strobe.start  = startReq;
  assign strobe.decide = stepEnd;
  assign strobe.commit = (state == ST_XFER);
  assign busyN   = (state == ST_TRACK);
  assign holdEn  = (state == ST_CONV);
  assign rcLevel = rcSync;
endmodule

// File: rtl/sar_conv_dp.sv
module sar_conv_dp
  import sar_conv_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  sarStrobe_t       strobe,
  input  logic             cmpHigh,
  input  logic             hiByteEn,
  input  logic             csN,
  input  logic             busyN,
  input  logic             rcLevel,
  output logic [WIDTH-1:0] dacCode,
  output logic [WIDTH-1:0] dataOut,
  output logic             dataOe
);
  localparam int HI_W = WIDTH - 8;  // bits above the low byte
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] trialMask, code, result, byteWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      code      <= '0;
      trialMask <= '0;
      result    <= '0;
    end else begin
      if (strobe.start) begin
        code      <= MSB_ONLY;
        trialMask <= MSB_ONLY;
      end else if (strobe.decide) begin
        code      <= (cmpHigh ? code : (code & ~trialMask)) | (trialMask >> 1);
        trialMask <= trialMask >> 1;
      end
      if (strobe.commit) result <= code;
    end
  end

  generate
    if (HI_W > 0) begin : g_byteSteer
      always_comb begin
        byteWord = '0;
        byteWord[WIDTH-1:8] = result[WIDTH-1:8];
        byteWord[HI_W-1:0]  = result[WIDTH-1:8];
      end
    end else begin : g_noSteer
      assign byteWord = result;
    end
  endgenerate

  assign dacCode = code;
  assign dataOut = hiByteEn ? byteWord : result;
  assign dataOe  = ~csN & busyN & rcLevel;
endmodule

// File: rtl/sar_conv_top.sv
module sar_conv_top
  import sar_conv_pkg::*;
#(
  parameter int WIDTH       = 12,
  parameter int STEP_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             rdConv,
  input  logic             hiByteEn,
  input  logic             cmpHigh,
  output logic [WIDTH-1:0] dacCode,
  output logic             holdEn,
  output logic             busyN,
  output logic [WIDTH-1:0] dataOut,
  output logic             dataOe
);
  sarStrobe_t strobe;
  logic rcLevel;

  sar_conv_ctrl #(.WIDTH(WIDTH), .STEP_CYCLES(STEP_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rdConv(rdConv), .hiByteEn(hiByteEn),
    .strobe(strobe), .busyN(busyN), .holdEn(holdEn), .rcLevel(rcLevel)
  );

  sar_conv_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpHigh(cmpHigh),
    .hiByteEn(hiByteEn), .csN(csN), .busyN(busyN), .rcLevel(rcLevel),
    .dacCode(dacCode), .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: rtl/sar_conv_chk.sv
module sar_conv_chk #(
  parameter int WIDTH       = 12,
  parameter int STEP_CYCLES = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             hiByteEn,
  input logic             busyN,
  input logic             holdEn,
  input logic             dataOe,
  input logic [WIDTH-1:0] dataOut,
  input logic [WIDTH-1:0] dacCode
);
  localparam int BUSY_CYCLES = WIDTH * STEP_CYCLES + 1;
  localparam int CNT_W = $clog2(BUSY_CYCLES + 2) + 1;
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [CNT_W-1:0] busyLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyLen <= '0;
    else if (!busyN) busyLen <= busyLen + 1'b1;
    else busyLen <= '0;
  end

  a_r1_start_gated: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyN) |-> $past(!csN && !hiByteEn));
  a_r2_busy_len: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyN) |-> (busyLen == CNT_W'(BUSY_CYCLES)));
  a_r3_bus_off_busy: assert property (@(posedge clk) disable iff (!rstN)
    !busyN |-> !dataOe);
  a_r4_bus_off_cs: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !dataOe);
  a_r6_nibble_low: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && hiByteEn) |-> (dataOut[7:4] == 4'h0));
  a_r8_msb_first: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyN) |-> (dacCode == MSB_ONLY));
  a_r9_hold_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    holdEn |-> !busyN);
  a_r9_track_before_ready: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdEn) |-> (!busyN ##1 busyN));
endmodule

bind sar_conv_top sar_conv_chk #(.WIDTH(WIDTH), .STEP_CYCLES(STEP_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .hiByteEn(hiByteEn), .busyN(busyN),
  .holdEn(holdEn), .dataOe(dataOe), .dataOut(dataOut), .dacCode(dacCode)
);

// File: tb/sar_conv_top_tb.sv
module sar_conv_top_tb;
  localparam int WIDTH = 12;
  localparam int STEP_CYCLES = 4;
  localparam int BUSY_CYCLES = WIDTH * STEP_CYCLES + 1;

  logic clk = 1'b0;
  logic rstN, csN, rdConv, hiByteEn, cmpHigh;
  logic [WIDTH-1:0] dacCode, dataOut, vin, prevRes;
  logic holdEn, busyN, dataOe;
  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  assign cmpHigh = (vin >= dacCode);  // ideal comparator model

  sar_conv_top #(.WIDTH(WIDTH), .STEP_CYCLES(STEP_CYCLES)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rdConv(rdConv), .hiByteEn(hiByteEn),
    .cmpHigh(cmpHigh), .dacCode(dacCode), .holdEn(holdEn), .busyN(busyN),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  function automatic logic [WIDTH-1:0] expBus(logic [WIDTH-1:0] r, logic hbe);
    if (!hbe) return r;
    return {r[11:8], 4'h0, r[11:8]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic refusedStart(string req, logic cs, logic hbe);
    rdConv = 1'b1; cyc(4);
    csN = cs; hiByteEn = hbe; cyc(1);
    rdConv = 1'b0; cyc(12);
    chk(req, busyN, 1'b1);
    csN = 1'b0; hiByteEn = 1'b0; cyc(2);
    rdConv = 1'b1; cyc(4);
  endtask

  task automatic convert(logic [WIDTH-1:0] v, bit readMode, bit lock);
    int n;
    bit oeSeen, firstHold, lastHold;
    vin = v;
    if (readMode) begin
      csN = 1'b1; rdConv = 1'b0; cyc(4);
      csN = 1'b0; cyc(1);
      rdConv = 1'b1; cyc(4);
      chk("R7 read pulse oe", dataOe, 1'b1);
      chk("R7 previous result", dataOut, prevRes);
      rdConv = 1'b0;
    end else begin
      rdConv = 1'b0; cyc(2);
      rdConv = 1'b1;
    end
    n = 0;
    while (busyN && n < 10) begin cyc(1); n++; end
    chk("R1 start accepted", busyN, 1'b0);
    n = 0; oeSeen = 0; firstHold = holdEn; lastHold = holdEn;
    while (!busyN && n < 1000) begin
      lastHold = holdEn;
      if (dataOe) oeSeen = 1;
      if (lock && (n == 6 || n == 10)) rdConv = ~rdConv;
      if (lock && n == 20) rdConv = ~rdConv;
      if (lock && n == 24) rdConv = ~rdConv;
      cyc(1); n++;
    end
    chk("R2 busy length", n, BUSY_CYCLES);
    chk("R3 bus off while busy", oeSeen, 1'b0);
    chk("R9 hold at start", firstHold, 1'b1);
    chk("R9 track in last busy cycle", lastHold, 1'b0);
    chk("R9 track while idle", holdEn, 1'b0);
    rdConv = 1'b1; cyc(4);
    chk("R3 no restart after busy", busyN, 1'b1);
    chk("R7 oe when selected and idle", dataOe, 1'b1);
    chk("R5 R8 full word result", dataOut, expBus(v, 1'b0));
    hiByteEn = 1'b1; cyc(1);
    chk("R6 byte steering", dataOut, expBus(v, 1'b1));
    hiByteEn = 1'b0; csN = 1'b1; cyc(1);
    chk("R4 deselected bus off", dataOe, 1'b0);
    csN = 1'b0; cyc(1);
    prevRes = v;
  endtask

  initial begin
    while (!finished && cycles < 100000) begin @(posedge clk); cycles++; end
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<%0d", cycles, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20251));
    rstN = 1'b0; csN = 1'b1; rdConv = 1'b1; hiByteEn = 1'b0; vin = '0; prevRes = '0;
    cyc(5);
    chk("R10 reset busy", busyN, 1'b1);
    chk("R10 reset hold", holdEn, 1'b0);
    chk("R10 reset oe", dataOe, 1'b0);
    rstN = 1'b1; csN = 1'b0; cyc(4);
    chk("R10 result zero", dataOut, '0);
    chk("R7 idle read enables bus", dataOe, 1'b1);

    refusedStart("R1 refused with cs high", 1'b1, 1'b0);
    refusedStart("R1 refused with hbe high", 1'b0, 1'b1);

    convert(12'h000, 0, 0);
    convert(12'hFFF, 0, 1);
    convert(12'h800, 1, 0);
    convert(12'h7FF, 0, 0);
    convert(12'h555, 1, 1);
    convert(12'hAAA, 0, 0);
    for (int i = 0; i < 24; i++) begin
      convert(WIDTH'($urandom), bit'($urandom & 1), bit'(($urandom >> 1) & 1));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule